// File: doc/BRIEF.md
# Dual-Port Seven-Slot Pixel Serializer

This block takes a pair of 24-bit pixels on each pixel period: a first (odd) pixel and a second (even) pixel. The two pixels share one set of data-enable, horizontal-sync and vertical-sync flags. The block arranges each pixel into four 7-bit lane words and generates a 7-bit clock-lane word for it. It then shifts all of these words out, one bit per slot, on two independent ports. Each port has four data lanes and one clock lane. The differential line drivers, the PLL and any deskew logic sit outside the block.

The block runs on a bit-rate clock. An external counter supplies a bit enable and a slot phase that counts from 0 to 6. A new pixel pair is captured on an enabled edge whose phase is 0. The remaining six enabled edges shift the words out, first slot first. A word strobe is high while slot 0 of each word is on the outputs.

Top module: `lvds_pair_packer`

## Requirements
- R1: While reset is asserted, and after it until the first load, every data lane, both clock lanes and the strobe are 0.
- R2: Data lane 0 presents, in slots 0 to 6, green bit 0, then red bits 5, 4, 3, 2, 1 and 0.
- R3: Data lane 1 presents, in slots 0 to 6, blue bit 1, blue bit 0, then green bits 5, 4, 3, 2 and 1.
- R4: Data lane 2 presents, in slots 0 to 6, DE, VSYNC, HSYNC, then blue bits 5, 4, 3 and 2. Slots 0 to 2 of this lane carry the same values on both ports.
- R5: Data lane 3 presents, in slots 0 to 6, a constant 0, blue bits 7 and 6, green bits 7 and 6, then red bits 7 and 6.
- R6: In slots 0 to 6 the clock lane of each port presents 1,1,0,0,0,1,1, so it is high in 4 of the 7 slots.
- R7: Pixel inputs are captured only on an edge where the bit enable is high and the phase is 0. Slot 0 is on the outputs in the following cycle, and the strobe is high exactly while slot 0 is shown.
- R8: Port 1 (p1_*) carries the odd (first) pixel. Port 2 (p2_*) carries the even (second) pixel.
- R9: While the bit enable is low, all outputs hold their values and pixel inputs are ignored.
- R10: Slot k of a word is on the outputs after the enabled edge with phase k. Enabled edges with a nonzero phase shift the word by one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-slot clock enable |
| phase | input | 3 | Slot phase of the current enabled edge, 0 to 6 |
| odd_r | input | 8 | Red of first pixel |
| odd_g | input | 8 | Green of first pixel |
| odd_b | input | 8 | Blue of first pixel |
| even_r | input | 8 | Red of second pixel |
| even_g | input | 8 | Green of second pixel |
| even_b | input | 8 | Blue of second pixel |
| de | input | 1 | Data enable, shared by both pixels |
| hsync | input | 1 | Horizontal sync, shared |
| vsync | input | 1 | Vertical sync, shared |
| p1_data | output | 4 | Port 1 serial data lanes, bit i is lane i |
| p1_clk | output | 1 | Port 1 clock lane |
| p2_data | output | 4 | Port 2 serial data lanes |
| p2_clk | output | 1 | Port 2 clock lane |
| word_strobe | output | 1 | High while slot 0 is presented |

## Verification
The hardest case to reach from the ports is a word that stalls in the middle of its slot sequence. During the stall the pixel inputs change, and a cycle with phase 0 arrives while the bit enable is low. The correct response is to hold the outputs and ignore both the new pixels and the phase. The bench sets this up by dropping the bit enable partway through selected words and scrambling the pixel and sync inputs during the gap. It then checks that the outputs did not move and that the deserialized word still matches the pair that was captured. Walking-one pixel patterns and their complements show that each colour bit reaches exactly one slot.

// File: rtl/lvds_pair_packer.sv
module lvds_pair_packer #(
  parameter int SLOTS = 7,
  parameter int LANES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [2:0] phase,
  input  logic [7:0] odd_r,
  input  logic [7:0] odd_g,
  input  logic [7:0] odd_b,
  input  logic [7:0] even_r,
  input  logic [7:0] even_g,
  input  logic [7:0] even_b,
  input  logic       de,
  input  logic       hsync,
  input  logic       vsync,
  output logic [3:0] p1_data,
  output logic       p1_clk,
  output logic [3:0] p2_data,
  output logic       p2_clk,
  output logic       word_strobe
);
  localparam int SRW = SLOTS * LANES;
  localparam logic [SLOTS-1:0] CLK_WORD = 7'b1100011;

  function automatic logic [SRW-1:0] pack(input logic [7:0] r, input logic [7:0] g,
                                          input logic [7:0] b, input logic d,
                                          input logic v, input logic h);
    logic [SLOTS-1:0] w0, w1, w2, w3;
    w0 = {g[0], r[5:0]};
    w1 = {b[1:0], g[5:1]};
    w2 = {d, v, h, b[5:2]};
    w3 = {1'b0, b[7:6], g[7:6], r[7:6]};
    return {w3, w2, w1, w0};
  endfunction

  logic [SRW-1:0]   sr1, sr2;
  logic [SLOTS-1:0] csr;
  wire              load = bit_en && (phase == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr1         <= '0;
      sr2         <= '0;
      csr         <= '0;
      word_strobe <= 1'b0;
    end else if (bit_en) begin
      word_strobe <= load;
      if (load) begin
        sr1 <= pack(odd_r, odd_g, odd_b, de, vsync, hsync);
        sr2 <= pack(even_r, even_g, even_b, de, vsync, hsync);
        csr <= CLK_WORD;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          sr1[l*SLOTS +: SLOTS] <= {sr1[l*SLOTS +: SLOTS-1], 1'b0};
          sr2[l*SLOTS +: SLOTS] <= {sr2[l*SLOTS +: SLOTS-1], 1'b0};
        end
        csr <= {csr[SLOTS-2:0], 1'b0};
      end
    end
  end

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      assign p1_data[gl] = sr1[gl*SLOTS + SLOTS-1];
      assign p2_data[gl] = sr2[gl*SLOTS + SLOTS-1];
    end
  endgenerate

  assign p1_clk = csr[SLOTS-1];
  assign p2_clk = csr[SLOTS-1];
endmodule

// File: rtl/lvds_pair_packer_chk.sv
module lvds_pair_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic [2:0] phase,
  input logic [3:0] p1_data,
  input logic       p1_clk,
  input logic [3:0] p2_data,
  input logic       p2_clk,
  input logic       word_strobe
);
  logic [2:0] slot;
  logic       loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      loaded <= 1'b0;
    end else if (bit_en) begin
      if (phase == 3'd0) begin
        slot   <= '0;
        loaded <= 1'b1;
      end else if (slot != 3'd7) begin
        slot <= slot + 3'd1;
      end
    end
  end

  // R7
  strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_strobe) |-> $past(bit_en) && ($past(phase) == 3'd0));

  // R6
  clk_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |-> p1_clk && p2_clk);

  // R6
  clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && slot >= 3'd2 && slot <= 3'd4) |-> !p1_clk && !p2_clk);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |-> !p1_data[3] && !p2_data[3]);

  // R4
  sync_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && slot <= 3'd2) |-> p1_data[2] == p2_data[2]);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(p1_data) && $stable(p2_data) && $stable(p1_clk) && $stable(word_strobe));
endmodule

bind lvds_pair_packer lvds_pair_packer_chk chk_i (.*);

// File: tb/lvds_pair_packer_tb_top.sv
module lvds_pair_packer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic [2:0] phase = '0;
  logic [7:0] odd_r = '0, odd_g = '0, odd_b = '0, even_r = '0, even_g = '0, even_b = '0;
  logic de = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [3:0] p1_data, p2_data;
  logic p1_clk, p2_clk, word_strobe;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvds_pair_packer dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_px(input logic [23:0] o, input logic [23:0] e, input logic [2:0] c);
    {odd_r, odd_g, odd_b} = o;
    {even_r, even_g, even_b} = e;
    {de, vsync, hsync} = c;
  endtask

  task automatic run_pair(input logic [23:0] o, input logic [23:0] e, input logic [2:0] c, input int stall_at);
    logic [6:0] w1 [4];
    logic [6:0] w2 [4];
    logic [6:0] c1, c2;
    logic [10:0] held;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      bit_en = 1'b1;
      phase = 3'(s);
      if (s == 0) drive_px(o, e, c);
      else drive_px(~o, ~e, ~c);
      @(posedge clk); #2;
      for (int l = 0; l < 4; l++) begin
        w1[l][6-s] = p1_data[l];
        w2[l][6-s] = p2_data[l];
      end
      c1[6-s] = p1_clk;
      c2[6-s] = p2_clk;
      chk(word_strobe == (s == 0), "R7 strobe", 32'(word_strobe), 32'(s == 0));
      if (s == stall_at) begin
        held = {p1_data, p2_data, p1_clk, p2_clk, word_strobe};
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          bit_en = 1'b0;
          phase = 3'd0;
          drive_px(24'(k * 24'h35a7c1), ~o, 3'(k));
          @(posedge clk); #2;
          chk({p1_data, p2_data, p1_clk, p2_clk, word_strobe} == held, "R9 hold",
              32'({p1_data, p2_data, p1_clk, p2_clk, word_strobe}), 32'(held));
        end
      end
    end
    // R2 R3 R5 R8 R10: recover both pixels from the deserialized lane words
    chk({w1[3][1:0], w1[0][5:0]} == o[23:16], "R2 R8 port1 red", 32'({w1[3][1:0], w1[0][5:0]}), 32'(o[23:16]));
    chk({w2[3][1:0], w2[0][5:0]} == e[23:16], "R2 R8 port2 red", 32'({w2[3][1:0], w2[0][5:0]}), 32'(e[23:16]));
    chk({w1[3][3:2], w1[1][4:0], w1[0][6]} == o[15:8], "R3 R10 port1 green", 32'({w1[3][3:2], w1[1][4:0], w1[0][6]}), 32'(o[15:8]));
    chk({w2[3][3:2], w2[1][4:0], w2[0][6]} == e[15:8], "R3 R10 port2 green", 32'({w2[3][3:2], w2[1][4:0], w2[0][6]}), 32'(e[15:8]));
    chk({w1[3][5:4], w1[2][3:0], w1[1][6:5]} == o[7:0], "R8 port1 blue", 32'({w1[3][5:4], w1[2][3:0], w1[1][6:5]}), 32'(o[7:0]));
    chk({w2[3][5:4], w2[2][3:0], w2[1][6:5]} == e[7:0], "R8 port2 blue", 32'({w2[3][5:4], w2[2][3:0], w2[1][6:5]}), 32'(e[7:0]));
    chk(w1[2][6:4] == c && w2[2][6:4] == c, "R4 sync slots", 32'({w1[2][6:4], w2[2][6:4]}), 32'({c, c}));
    chk(!w1[3][6] && !w2[3][6], "R5 reserved", 32'({w1[3][6], w2[3][6]}), 32'h0);
    chk(c1 == 7'b1100011 && c2 == 7'b1100011, "R6 clock lane", 32'({c1, c2}), 32'({7'b1100011, 7'b1100011}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0;
    // R1
    chk({p1_data, p2_data, p1_clk, p2_clk, word_strobe} == 11'h0, "R1 reset outputs",
        32'({p1_data, p2_data, p1_clk, p2_clk, word_strobe}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({p1_data, p2_data, p1_clk, p2_clk, word_strobe} == 11'h0, "R1 idle after reset",
        32'({p1_data, p2_data, p1_clk, p2_clk, word_strobe}), 32'h0);
    for (int i = 0; i < 24; i++)
      run_pair(24'(1) << i, ~(24'(1) << i), 3'(i), (i % 5 == 0) ? (i % 7) : -1);
    for (int i = 0; i < 24; i++)
      run_pair(~(24'(1) << i), 24'(1) << (23 - i), 3'(7 - (i % 8)), -1);
    for (int i = 0; i < 20; i++)
      run_pair(24'(i * 24'h1f3b57 + 24'h0a0a0a), 24'(i * 24'h9e3779 ^ 24'h5a5a5a), 3'(i * 3),
               (i % 3 == 0) ? (i % 7) : -1);
    @(negedge clk);
    bit_en = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule